// File: doc/BRIEF.md
# HI/LO Multiply-Divide Register Unit

This block holds the pair of 32-bit result registers, HI and LO, that sit beside a processor's integer datapath, together with the arithmetic that fills them. A multiply produces a double-width product that is split across the pair. A divide leaves its quotient in LO and its remainder in HI. Two move-in operations load one half from a source operand. Two move-out operations return one half to the requester.

Multiply completes in the cycle it is accepted. Divide uses an iterative restoring engine that takes one cycle per result bit. While it runs, `op_ready` is low, so any operation that is issued, including a move-out, waits until the result has been written.

Each half carries an observable "defined" flag. If a move-in overwrites one half of a multiply or divide result before any move-out has read that result, the other half is marked undefined. Signed multiply and divide are an elaboration option.

Top module: `hilo_muldiv_unit`

## Requirements
- R1: `op_code` encoding: 0 unsigned multiply, 1 unsigned divide, 2 move-in HI, 3 move-in LO, 4 move-out HI, 5 move-out LO, 6 signed multiply, 7 signed divide. An operation is accepted on a rising edge where `op_valid` and `op_ready` are both high. An accepted unsigned multiply writes the 2W-bit product of `src_a` and `src_b`: the upper W bits go to HI and the lower W bits go to LO, at that same edge.
- R2: An accepted divide (`src_a` is the dividend, `src_b` the divisor) raises `busy` and lowers `op_ready` for exactly W cycles. It then writes the quotient to LO and the remainder to HI.
- R3: A divide by zero completes in the same W cycles. It leaves LO all ones and HI equal to the dividend, for both signed and unsigned divide.
- R4: Move-in HI copies `src_a` into HI, and move-in LO copies `src_a` into LO. The other half keeps its value.
- R5: A move-out accepted at an edge drives `rd_valid` high for the next cycle, with `rd_data` holding the half as it was at acceptance. A move-out issued during a divide is held off and returns that divide's result.
- R6: A move-in HI accepted while a multiply or divide result has not yet been read clears `lo_defined`. A move-in LO in the same position clears `hi_defined`.
- R7: A move-in always sets its own half's flag. Once a move-out or a move-in has followed the last full result, a move-in leaves the other half's flag unchanged.
- R8: A completed multiply or divide sets both `hi_defined` and `lo_defined`.
- R9: Reset clears HI and LO to zero, sets both defined flags, and leaves the unit idle with `op_ready` high.
- R10: Signed operations use two's complement. The quotient truncates toward zero and the remainder takes the dividend's sign. The most negative value divided by -1 gives a quotient of the most negative value and a remainder of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request |
| op_code | input | 3 | Operation select (see R1) |
| src_a | input | W | Multiplicand, dividend or move-in data |
| src_b | input | W | Multiplier or divisor |
| op_ready | output | 1 | Unit can accept an operation |
| busy | output | 1 | Divide in progress |
| rd_valid | output | 1 | Move-out data valid |
| rd_data | output | W | Move-out data |
| hi_defined | output | 1 | HI content is defined |
| lo_defined | output | 1 | LO content is defined |

## Verification
The hardest case to reach is a move-out that arrives while a divide is still iterating. The bench creates it by issuing each divide and then presenting the move-out on the very next cycle, without waiting for `busy` to fall. The held request must then deliver that divide's remainder and quotient. Divide-by-zero and the most-negative-by-minus-one case sit inside the operand sweeps and are also applied as explicit corner vectors. The flag rules are reached by following a full result with a move-in, both with and without an intervening move-out.

// File: rtl/hilo_pkg.sv
package hilo_pkg;

  typedef enum logic [2:0] {
    OP_MULTU = 3'd0,
    OP_DIVU  = 3'd1,
    OP_MTHI  = 3'd2,
    OP_MTLO  = 3'd3,
    OP_MFHI  = 3'd4,
    OP_MFLO  = 3'd5,
    OP_MULT  = 3'd6,
    OP_DIV   = 3'd7
  } hilo_op_e;

endpackage

// File: rtl/hilo_mul.sv
module hilo_mul #(
  parameter int W         = 32,
  parameter bit SIGNED_EN = 1'b1
) (
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           is_signed,
  output logic [2*W-1:0] prod
);

  generate
    if (SIGNED_EN) begin : g_signed
      logic           neg_a, neg_b;
      logic [W-1:0]   mag_a, mag_b;
      logic [2*W-1:0] mag_p;

      always_comb begin
        neg_a = is_signed & a[W-1];
        neg_b = is_signed & b[W-1];
        mag_a = neg_a ? (~a + 1'b1) : a;
        mag_b = neg_b ? (~b + 1'b1) : b;
        mag_p = {{W{1'b0}}, mag_a} * {{W{1'b0}}, mag_b};
        prod  = (neg_a ^ neg_b) ? (~mag_p + 1'b1) : mag_p;
      end
    end else begin : g_unsigned
      logic unused_sel;
      assign unused_sel = is_signed;
      assign prod = {{W{1'b0}}, a} * {{W{1'b0}}, b};
    end
  endgenerate

endmodule

// File: rtl/hilo_div.sv
module hilo_div #(
  parameter int W         = 32,
  parameter bit SIGNED_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         is_signed,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quo,
  output logic [W-1:0] rem
);

  localparam int CW = $clog2(W + 1);

  logic          busy_q, busy_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [W-1:0]  rem_q, rem_n, quo_q, quo_n, dvs_q, dvs_n;
  logic          negq_q, negq_n, negr_q, negr_n, zero_q, zero_n;
  logic          adv;

  logic          sgn, neg_a, neg_b;
  logic [W:0]    shifted, trial;
  logic          fits;
  logic [W-1:0]  rem_step, quo_step;

  always_comb begin
    sgn      = SIGNED_EN & is_signed;
    neg_a    = sgn & dividend[W-1];
    neg_b    = sgn & divisor[W-1];

    shifted  = {rem_q, quo_q[W-1]};
    trial    = shifted - {1'b0, dvs_q};
    fits     = ~trial[W];
    rem_step = fits ? trial[W-1:0] : shifted[W-1:0];
    quo_step = {quo_q[W-2:0], fits};

    busy_n = busy_q;
    cnt_n  = cnt_q;
    rem_n  = rem_q;
    quo_n  = quo_q;
    dvs_n  = dvs_q;
    negq_n = negq_q;
    negr_n = negr_q;
    zero_n = zero_q;

    if (start) begin
      busy_n = 1'b1;
      cnt_n  = CW'(W);
      rem_n  = '0;
      quo_n  = neg_a ? (~dividend + 1'b1) : dividend;
      dvs_n  = neg_b ? (~divisor + 1'b1) : divisor;
      negq_n = neg_a ^ neg_b;
      negr_n = neg_a;
      zero_n = (divisor == '0);
    end else if (busy_q) begin
      rem_n  = rem_step;
      quo_n  = quo_step;
      cnt_n  = cnt_q - 1'b1;
      busy_n = (cnt_q != CW'(1));
    end
  end

  assign adv = start | busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      rem_q  <= '0;
      quo_q  <= '0;
      dvs_q  <= '0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
    end else if (adv) begin
      busy_q <= busy_n;
      cnt_q  <= cnt_n;
      rem_q  <= rem_n;
      quo_q  <= quo_n;
      dvs_q  <= dvs_n;
      negq_q <= negq_n;
      negr_q <= negr_n;
      zero_q <= zero_n;
    end
  end

  assign busy = busy_q;
  assign done = busy_q & (cnt_q == CW'(1));
  assign quo  = zero_q ? '1 : (negq_q ? (~quo_step + 1'b1) : quo_step);
  assign rem  = negr_q ? (~rem_step + 1'b1) : rem_step;

  // R2
  div_start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy);

  // R2
  div_done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

endmodule

// File: rtl/hilo_muldiv_unit.sv
module hilo_muldiv_unit #(
  parameter int W         = 32,
  parameter bit SIGNED_EN = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         op_valid,
  input  logic [2:0]   op_code,
  input  logic [W-1:0] src_a,
  input  logic [W-1:0] src_b,
  output logic         op_ready,
  output logic         busy,
  output logic         rd_valid,
  output logic [W-1:0] rd_data,
  output logic         hi_defined,
  output logic         lo_defined
);
  import hilo_pkg::*;

  hilo_op_e       op;
  logic           accept, is_mul, is_div, signed_op;
  logic [2*W-1:0] prod;
  logic           div_busy, div_done;
  logic [W-1:0]   div_quo, div_rem;

  logic [W-1:0]   hi_q, hi_n, lo_q, lo_n, rd_q, rd_n;
  logic           hdef_q, hdef_n, ldef_q, ldef_n, pend_q, pend_n, rdv_q, rdv_n;
  logic           reg_en;

  assign op        = hilo_op_e'(op_code);
  assign op_ready  = ~div_busy;
  assign accept    = op_valid & op_ready;
  assign is_mul    = (op == OP_MULTU) | (op == OP_MULT);
  assign is_div    = (op == OP_DIVU)  | (op == OP_DIV);
  assign signed_op = (op == OP_MULT)  | (op == OP_DIV);

  hilo_mul #(.W(W), .SIGNED_EN(SIGNED_EN)) u_mul (
    .a(src_a), .b(src_b), .is_signed(signed_op), .prod(prod)
  );

  hilo_div #(.W(W), .SIGNED_EN(SIGNED_EN)) u_div (
    .clk(clk), .rst_n(rst_n), .start(accept & is_div), .is_signed(signed_op),
    .dividend(src_a), .divisor(src_b), .busy(div_busy), .done(div_done),
    .quo(div_quo), .rem(div_rem)
  );

  always_comb begin
    hi_n   = hi_q;
    lo_n   = lo_q;
    hdef_n = hdef_q;
    ldef_n = ldef_q;
    pend_n = pend_q;
    rd_n   = rd_q;
    rdv_n  = 1'b0;
    if (div_done) begin
      hi_n   = div_rem;
      lo_n   = div_quo;
      hdef_n = 1'b1;
      ldef_n = 1'b1;
      pend_n = 1'b1;
    end else if (accept) begin
      if (is_mul) begin
        hi_n   = prod[2*W-1:W];
        lo_n   = prod[W-1:0];
        hdef_n = 1'b1;
        ldef_n = 1'b1;
        pend_n = 1'b1;
      end else if (op == OP_MTHI) begin
        hi_n   = src_a;
        hdef_n = 1'b1;
        if (pend_q) ldef_n = 1'b0;
        pend_n = 1'b0;
      end else if (op == OP_MTLO) begin
        lo_n   = src_a;
        ldef_n = 1'b1;
        if (pend_q) hdef_n = 1'b0;
        pend_n = 1'b0;
      end else if (op == OP_MFHI) begin
        rd_n   = hi_q;
        rdv_n  = 1'b1;
        pend_n = 1'b0;
      end else if (op == OP_MFLO) begin
        rd_n   = lo_q;
        rdv_n  = 1'b1;
        pend_n = 1'b0;
      end
    end
  end

  assign reg_en = accept | div_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= '0;
      lo_q   <= '0;
      hdef_q <= 1'b1;
      ldef_q <= 1'b1;
      pend_q <= 1'b0;
      rd_q   <= '0;
    end else if (reg_en) begin
      hi_q   <= hi_n;
      lo_q   <= lo_n;
      hdef_q <= hdef_n;
      ldef_q <= ldef_n;
      pend_q <= pend_n;
      rd_q   <= rd_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdv_q <= 1'b0;
    else        rdv_q <= rdv_n;
  end

  assign busy       = div_busy;
  assign rd_valid   = rdv_q;
  assign rd_data    = rd_q;
  assign hi_defined = hdef_q;
  assign lo_defined = ldef_q;

  // R1
  mul_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_MULTU)) |=>
      ({hi_q, lo_q} == ($past({{W{1'b0}}, src_a}) * $past({{W{1'b0}}, src_b}))));

  // R4
  mtlo_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_MTLO)) |=> ((lo_q == $past(src_a)) && $stable(hi_q)));

  // R5
  read_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_MFHI)) |=> (rd_valid && (rd_data == $past(hi_q))));

  // R6
  mthi_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (op == OP_MTHI) && pend_q) |=> (!lo_defined && hi_defined));

  // R8
  full_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    div_done |=> (hi_defined && lo_defined && op_ready));

endmodule

// File: tb/hilo_muldiv_unit_bench.sv
module hilo_muldiv_unit_bench;

  localparam int CLK_PERIOD = 10;
  localparam int BW         = 8;

  logic          clk, rst_n, op_valid;
  logic [2:0]    op_code;
  logic [BW-1:0] src_a, src_b;
  logic          op_ready, busy, rd_valid, hi_defined, lo_defined;
  logic [BW-1:0] rd_data;

  int n_chk  = 0;
  int n_fail = 0;

  hilo_muldiv_unit #(.W(BW), .SIGNED_EN(1'b1)) u_hilo_muldiv_unit (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .op_ready(op_ready), .busy(busy),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .hi_defined(hi_defined), .lo_defined(lo_defined)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [BW-1:0] act, input logic [BW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [BW-1:0] x, input logic [BW-1:0] y);
    op_valid = 1'b1;
    op_code  = op;
    src_a    = x;
    src_b    = y;
    while (!op_ready) @(negedge clk);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  task automatic read(input logic [2:0] op, output logic [BW-1:0] v);
    issue(op, '0, '0);
    v = rd_valid ? rd_data : 'x;
  endtask

  task automatic check_pair(input string req, input logic [BW-1:0] eh, input logic [BW-1:0] el);
    logic [BW-1:0] v;
    read(3'd4, v);
    check({req, " HI"}, v, eh);
    read(3'd5, v);
    check({req, " LO"}, v, el);
  endtask

  task automatic div_vec(input bit sgn, input int x, input int y);
    logic [BW-1:0] eh, el;
    if (y[BW-1:0] == '0) begin
      el = '1;
      eh = x[BW-1:0];
    end else if (sgn) begin
      el = BW'(x / y);
      eh = BW'(x % y);
    end else begin
      el = BW'(x[BW-1:0] / y[BW-1:0]);
      eh = BW'(x[BW-1:0] % y[BW-1:0]);
    end
    issue(sgn ? 3'd7 : 3'd1, x[BW-1:0], y[BW-1:0]);
    check_pair(y[BW-1:0] == '0 ? "R3 divzero" : (sgn ? "R10 sdiv" : "R2 divu"), eh, el);
  endtask

  task automatic mul_vec(input bit sgn, input int x, input int y);
    logic [2*BW-1:0] p;
    p = sgn ? (2*BW)'(x * y) : (2*BW)'(x[BW-1:0] * y[BW-1:0]);
    issue(sgn ? 3'd6 : 3'd0, x[BW-1:0], y[BW-1:0]);
    check_pair(sgn ? "R10 smul" : "R1 multu", p[2*BW-1:BW], p[BW-1:0]);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [BW-1:0] v;
    int cnt;
    rst_n = 1'b0; op_valid = 1'b0; op_code = '0; src_a = '0; src_b = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9 reset state
    check("R9 op_ready", {7'd0, op_ready}, 8'd1);
    check("R9 hi_defined", {7'd0, hi_defined}, 8'd1);
    check("R9 lo_defined", {7'd0, lo_defined}, 8'd1);
    check_pair("R9 reset value", 8'h00, 8'h00);

    // R5 read strobe lasts one cycle
    issue(3'd4, '0, '0);
    check("R5 rd_valid high", {7'd0, rd_valid}, 8'd1);
    @(negedge clk);
    check("R5 rd_valid drops", {7'd0, rd_valid}, 8'd0);

    // R2 busy duration and op_ready held low
    issue(3'd1, 8'd200, 8'd7);
    cnt = 0;
    while (busy) begin
      cnt++;
      if (op_ready) check("R2 op_ready during busy", 8'd1, 8'd0);
      @(negedge clk);
    end
    check("R2 busy cycles", BW'(cnt), BW'(BW));
    check_pair("R2 divu", 8'd4, 8'd28);

    // R3 divide by zero, same duration
    issue(3'd1, 8'd91, 8'd0);
    cnt = 0;
    while (busy) begin cnt++; @(negedge clk); end
    check("R3 busy cycles", BW'(cnt), BW'(BW));
    check_pair("R3 divzero", 8'd91, 8'hFF);

    // R1 unsigned multiply sweep
    for (int ia = 0; ia < 256; ia += 3)
      for (int ib = 0; ib < 256; ib += 5)
        mul_vec(1'b0, ia, ib);
    mul_vec(1'b0, 255, 255);

    // R2 R3 R5 unsigned divide sweep; reads issued while busy
    for (int ia = 0; ia < 256; ia += 5)
      for (int ib = 0; ib < 256; ib += 7)
        div_vec(1'b0, ia, ib);
    div_vec(1'b0, 255, 1);
    div_vec(1'b0, 255, 255);
    div_vec(1'b0, 1, 255);
    div_vec(1'b0, 0, 0);

    // R10 signed sweep
    for (int ia = -128; ia < 128; ia += 9)
      for (int ib = -128; ib < 128; ib += 13) begin
        mul_vec(1'b1, ia, ib);
        div_vec(1'b1, ia, ib);
      end
    div_vec(1'b1, -128, -1);
    div_vec(1'b1, -128, 0);
    div_vec(1'b1, -5, 0);
    div_vec(1'b1, 7, -2);
    mul_vec(1'b1, -128, -128);

    // R4 R6 move-in HI after unread multiply
    issue(3'd0, 8'd16, 8'd17);
    issue(3'd2, 8'hA5, '0);
    check("R6 lo_defined after MTHI", {7'd0, lo_defined}, 8'd0);
    check("R7 hi_defined after MTHI", {7'd0, hi_defined}, 8'd1);
    check_pair("R4 MTHI keeps LO", 8'hA5, 8'h10);

    // R8 full result restores both flags
    issue(3'd0, 8'd3, 8'd3);
    check("R8 lo_defined", {7'd0, lo_defined}, 8'd1);
    check("R8 hi_defined", {7'd0, hi_defined}, 8'd1);

    // R6 move-in LO after unread divide
    issue(3'd1, 8'd50, 8'd6);
    issue(3'd3, 8'h3C, '0);
    check("R6 hi_defined after MTLO", {7'd0, hi_defined}, 8'd0);
    check("R7 lo_defined after MTLO", {7'd0, lo_defined}, 8'd1);
    check_pair("R4 MTLO keeps HI", 8'd2, 8'h3C);

    // R7 after a read, move-in leaves other flag
    issue(3'd0, 8'd9, 8'd9);
    read(3'd5, v);
    check("R7 read value", v, 8'd81);
    issue(3'd2, 8'h11, '0);
    check("R7 lo kept defined", {7'd0, lo_defined}, 8'd1);
    issue(3'd3, 8'h22, '0);
    check("R7 hi kept defined", {7'd0, hi_defined}, 8'd1);
    check_pair("R4 both moves", 8'h11, 8'h22);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule